// File: doc/BRIEF.md
# I2C Quasi-Bidirectional 16-Bit Port Expander

This block is an I2C target that gives a host controller sixteen general-purpose pins, arranged as a low group (bits 7..0) and a high group (bits 15..8). There is no direction register. Writing a 0 to a bit makes the block hold that pin low. Writing a 1 releases the pin to its weak pull-up, so the bit can then be read as an input. A bit that has just been written to 1 also gets a short strong pull-up enable, which ends on the next SCL falling edge. A read returns the levels present on the pins.

The serial inputs come from a fast system clock that oversamples them. Each line is resynchronized and then filtered, so pulses shorter than the filter length are thrown away. START, repeated START and STOP are recognised from SDA edges while SCL is high. The 7-bit target address is `0100` followed by three strap inputs. Up to eight of these blocks can therefore share one bus.

An active-low interrupt output is meant to drive an open-drain pad. It goes low when a released pin changes level, and it returns high when this target next acknowledges its address.

Top module: `pexp16_top`

## Requirements
- R1: After reset the output latch is all ones. No pin is pulled low, no strong pull-up is enabled, `irq_n` is 1 and SDA is released.
- R2: The target acknowledges only the 7-bit address {4'b0100, `addr_sel`}. Address bit 0 after the seven address bits selects the direction: 0 means write, 1 means read. A transfer to any other address gets no acknowledge and does not change the latch.
- R3: In a write, data bytes go to the low group, then the high group, and keep alternating for further bytes. `pin_pull_low` is the bitwise inverse of the latch.
- R4: A written byte reaches the pins only at the SCL falling edge that ends its acknowledge bit. Before that edge the pins keep their old values.
- R5: When a byte is applied, `pin_boost` is set for the bits of that group written as 1. It is cleared on the next SCL falling edge.
- R6: In a read, the target returns the pin levels MSB first, low group first and then high group. A controller NACK ends the read.
- R7: The target changes SDA only while SCL is low.
- R8: A STOP or a repeated START in the middle of a data byte throws away the partial byte. The latch is not changed by it.
- R9: A level change on any pin whose latch bit is 1 drives `irq_n` low. `irq_n` goes back high when this target acknowledges its address.
- R10: A pulse on SCL or SDA shorter than FILT_LEN clock cycles has no effect on the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| sda_pull_low | output | 1 | 1 pulls SDA low (acknowledge or read data 0) |
| addr_sel | input | 3 | Strapped low bits of the target address |
| pin_in | input | 16 | Sensed levels of the port pins |
| pin_pull_low | output | 16 | 1 drives the pin low (latch bit is 0) |
| pin_boost | output | 16 | 1 enables the strong pull-up of the pin |
| irq_n | output | 1 | Active-low interrupt, for an open-drain pad |

## Verification
The assertions assume that the controller changes SDA only while SCL is low, except when it signals START or STOP. They also assume that the controller never signals a START or STOP while the target holds SDA low, and that a spike on a bus line is shorter than the filter length. The bench master meets these assumptions with a quarter bit time of ten clock cycles, which is well above the five-cycle synchronizer and filter delay. The only exception is the R10 scenario, where the master adds two-cycle spikes on purpose. Pin levels change only between transfers or while the bus is idle, so each read snapshot and each interrupt event is unambiguous.

// File: rtl/pexp_pkg.sv
// Shared constants and types of the 16-bit port expander.
// Assumes bytes of eight bits; the port width is a multiple of a byte.
package pexp_pkg;

    localparam int BYTE_W = 8;
    localparam logic [3:0] DEV_PREFIX = 4'b0100;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_AACK,
        S_WDAT,
        S_WACK,
        S_RDAT,
        S_RACK
    } bus_state_t;

endpackage

// File: rtl/pexp_filter.sv
// Bus line conditioner: resynchronizes SCL and SDA, rejects pulses shorter
// than FILT_LEN cycles, then derives edge and START/STOP events.
// Assumes the idle bus level is high on both lines.
module pexp_filter #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    localparam int CNT_W = (FILT_LEN > 1) ? $clog2(FILT_LEN + 1) : 1;

    logic [1:0] raw_v;
    logic [1:0] filt_v;
    logic       scl_q;
    logic       sda_q;

    assign raw_v = {sda_raw, scl_raw};

    for (genvar ln = 0; ln < 2; ln++) begin : g_line
        logic [1:0]       sync;
        logic [CNT_W-1:0] cnt;
        logic             filt;

        // Two-stage resync followed by a persistence counter.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sync <= 2'b11;
                cnt  <= '0;
                filt <= 1'b1;
            end else begin
                sync <= {sync[0], raw_v[ln]};
                if (sync[1] != filt) begin
                    if (cnt == CNT_W'(FILT_LEN - 1)) begin
                        filt <= sync[1];
                        cnt  <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end else begin
                    cnt <= '0;
                end
            end
        end

        assign filt_v[ln] = filt;
    end

    assign scl_lvl = filt_v[0];
    assign sda_lvl = filt_v[1];

    // Previous filtered levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_lvl;
            sda_q <= sda_lvl;
        end
    end

    assign scl_rise = scl_lvl & ~scl_q;
    assign scl_fall = ~scl_lvl & scl_q;
    assign start_ev = scl_lvl & scl_q & ~sda_lvl & sda_q;
    assign stop_ev  = scl_lvl & scl_q & sda_lvl & ~sda_q;

    // R10: at most one bus event per cycle after filtering.
    a_r10_event_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({scl_rise, scl_fall, start_ev, stop_ev}));

endmodule

// File: rtl/pexp_engine.sv
// I2C target protocol engine: address match, write bytes to port groups in
// rotation, and serve pin snapshots on reads.
// Assumes filtered bus events from pexp_filter; SDA is driven only on SCL fall.
module pexp_engine
    import pexp_pkg::*;
#(
    parameter int PORT_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_lvl,
    input  logic                sda_lvl,
    input  logic                scl_rise,
    input  logic                scl_fall,
    input  logic                start_ev,
    input  logic                stop_ev,
    input  logic [2:0]          addr_sel,
    input  logic [PORT_W-1:0]   pin_sync,
    output logic                sda_lo,
    output logic                addr_hit,
    output logic                wr_stb,
    output logic [((PORT_W/BYTE_W) > 1 ? $clog2(PORT_W/BYTE_W) : 1)-1:0] wr_grp,
    output logic [BYTE_W-1:0]   wr_data
);
    localparam int NUM_GRP = PORT_W / BYTE_W;
    localparam int GRP_IW  = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1;
    localparam logic [3:0] BITS_FULL = 4'(BYTE_W);

    bus_state_t          state;
    logic [3:0]          bitcnt;
    logic [BYTE_W-1:0]   shreg;
    logic                rw;
    logic                ack_ok;
    logic [GRP_IW-1:0]   grp;
    logic [PORT_W-1:0]   snap;

    function automatic logic [GRP_IW-1:0] next_grp(input logic [GRP_IW-1:0] g);
        return (g == GRP_IW'(NUM_GRP - 1)) ? '0 : g + 1'b1;
    endfunction

    // Protocol sequencer: one step per filtered bus event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            bitcnt   <= '0;
            shreg    <= '0;
            rw       <= 1'b0;
            ack_ok   <= 1'b0;
            grp      <= '0;
            snap     <= '0;
            sda_lo   <= 1'b0;
            addr_hit <= 1'b0;
            wr_stb   <= 1'b0;
            wr_grp   <= '0;
            wr_data  <= '0;
        end else begin
            addr_hit <= 1'b0;
            wr_stb   <= 1'b0;
            if (start_ev) begin
                state  <= S_ADDR;
                bitcnt <= '0;
                grp    <= '0;
                sda_lo <= 1'b0;
            end else if (stop_ev) begin
                state  <= S_IDLE;
                sda_lo <= 1'b0;
            end else begin
                case (state)
                    S_ADDR: begin
                        if (scl_rise) begin
                            shreg  <= {shreg[BYTE_W-2:0], sda_lvl};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (scl_fall && bitcnt == BITS_FULL) begin
                            if (shreg[BYTE_W-1:1] == {DEV_PREFIX, addr_sel}) begin
                                sda_lo   <= 1'b1;
                                rw       <= shreg[0];
                                addr_hit <= 1'b1;
                                state    <= S_AACK;
                            end else begin
                                state <= S_IDLE;
                            end
                        end
                    end
                    S_AACK: begin
                        if (scl_rise && rw) begin
                            snap <= pin_sync;
                        end else if (scl_fall) begin
                            bitcnt <= '0;
                            if (rw) begin
                                shreg  <= snap[grp*BYTE_W +: BYTE_W];
                                sda_lo <= ~snap[grp*BYTE_W + BYTE_W - 1];
                                state  <= S_RDAT;
                            end else begin
                                sda_lo <= 1'b0;
                                state  <= S_WDAT;
                            end
                        end
                    end
                    S_WDAT: begin
                        if (scl_rise) begin
                            shreg  <= {shreg[BYTE_W-2:0], sda_lvl};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (scl_fall && bitcnt == BITS_FULL) begin
                            sda_lo <= 1'b1;
                            state  <= S_WACK;
                        end
                    end
                    S_WACK: begin
                        if (scl_fall) begin
                            sda_lo  <= 1'b0;
                            wr_stb  <= 1'b1;
                            wr_grp  <= grp;
                            wr_data <= shreg;
                            grp     <= next_grp(grp);
                            bitcnt  <= '0;
                            state   <= S_WDAT;
                        end
                    end
                    S_RDAT: begin
                        if (scl_rise) begin
                            bitcnt <= bitcnt + 1'b1;
                        end else if (scl_fall) begin
                            if (bitcnt == BITS_FULL) begin
                                sda_lo <= 1'b0;
                                grp    <= next_grp(grp);
                                state  <= S_RACK;
                            end else begin
                                shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                                sda_lo <= ~shreg[BYTE_W-2];
                            end
                        end
                    end
                    S_RACK: begin
                        if (scl_rise) begin
                            ack_ok <= ~sda_lvl;
                            if (!sda_lvl) snap <= pin_sync;
                        end else if (scl_fall) begin
                            if (ack_ok) begin
                                bitcnt <= '0;
                                shreg  <= snap[grp*BYTE_W +: BYTE_W];
                                sda_lo <= ~snap[grp*BYTE_W + BYTE_W - 1];
                                state  <= S_RDAT;
                            end else begin
                                state <= S_IDLE;
                            end
                        end
                    end
                    default: state <= S_IDLE;
                endcase
            end
        end
    end

    // R7: SDA drive is frozen while SCL stays high.
    a_r7_sda_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_lvl && $past(scl_lvl)) |-> $stable(sda_lo));

    // R2: no pull on SDA while receiving address or write data, or idle.
    a_r2_no_drive_receiving: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE || state == S_ADDR || state == S_WDAT) |-> !sda_lo);

endmodule

// File: rtl/pexp_port.sv
// Port side: output latch per byte group, strong pull-up pulse, pin resync
// and change interrupt.
// Assumes pin levels are asynchronous; they are resynchronized here.
module pexp_port
    import pexp_pkg::*;
#(
    parameter int PORT_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PORT_W-1:0]   pin_raw,
    input  logic                scl_fall,
    input  logic                addr_hit,
    input  logic                wr_stb,
    input  logic [((PORT_W/BYTE_W) > 1 ? $clog2(PORT_W/BYTE_W) : 1)-1:0] wr_grp,
    input  logic [BYTE_W-1:0]   wr_data,
    output logic [PORT_W-1:0]   pin_sync,
    output logic [PORT_W-1:0]   latch,
    output logic [PORT_W-1:0]   boost,
    output logic                irq_n
);
    localparam int NUM_GRP = PORT_W / BYTE_W;
    localparam int GRP_IW  = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1;

    logic [PORT_W-1:0] pin_s1;
    logic [PORT_W-1:0] pin_prev;
    logic              chg;
    logic              irq_q;

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        logic [BYTE_W-1:0] lat;
        logic [BYTE_W-1:0] bst;

        // Group latch and its strong pull-up pulse.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lat <= '1;
                bst <= '0;
            end else if (wr_stb && wr_grp == GRP_IW'(g)) begin
                lat <= wr_data;
                bst <= wr_data;
            end else if (scl_fall) begin
                bst <= '0;
            end
        end

        assign latch[g*BYTE_W +: BYTE_W] = lat;
        assign boost[g*BYTE_W +: BYTE_W] = bst;
    end

    // Pin resynchronizer and previous-sample register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_s1   <= '1;
            pin_sync <= '1;
            pin_prev <= '1;
        end else begin
            pin_s1   <= pin_raw;
            pin_sync <= pin_s1;
            pin_prev <= pin_sync;
        end
    end

    assign chg = |((pin_sync ^ pin_prev) & latch);

    // Interrupt flag: set by a released-pin change, cleared by address ack.
    always_ff @(posedge clk) begin
        if (!rst_n)        irq_q <= 1'b0;
        else if (chg)      irq_q <= 1'b1;
        else if (addr_hit) irq_q <= 1'b0;
    end

    assign irq_n = ~irq_q;

    // R1: state right after reset release.
    always @(posedge clk) begin
        if (rst_n && $past(rst_n) == 1'b0)
            a_r1_reset_state: assert (latch == '1 && boost == '0 && irq_n == 1'b1);
    end

    // R5: strong pull-up only on bits latched high.
    a_r5_boost_on_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (boost & ~latch) == '0);

    // R5: a falling SCL with no write ends every pulse.
    a_r5_boost_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_fall && !wr_stb) |=> boost == '0);

    // R9: address ack with no new change releases the interrupt.
    a_r9_irq_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_hit && !chg) |=> irq_n);

endmodule

// File: rtl/pexp16_top.sv
// Top of the I2C quasi-bidirectional port expander: bus conditioner,
// protocol engine and port logic.
// Assumes scl_i/sda_i are the wired bus levels sampled by clk.
module pexp16_top #(
    parameter int PORT_W   = 16,
    parameter int FILT_LEN = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_pull_low,
    input  logic [2:0]        addr_sel,
    input  logic [PORT_W-1:0] pin_in,
    output logic [PORT_W-1:0] pin_pull_low,
    output logic [PORT_W-1:0] pin_boost,
    output logic              irq_n
);
    import pexp_pkg::*;

    localparam int NUM_GRP = PORT_W / BYTE_W;
    localparam int GRP_IW  = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1;

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;
    logic addr_hit, wr_stb;
    logic [GRP_IW-1:0] wr_grp;
    logic [BYTE_W-1:0] wr_data;
    logic [PORT_W-1:0] pin_sync;
    logic [PORT_W-1:0] latch;

    pexp_filter #(.FILT_LEN(FILT_LEN)) u_filt (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_raw  (scl_i),
        .sda_raw  (sda_i),
        .scl_lvl  (scl_lvl),
        .sda_lvl  (sda_lvl),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    pexp_engine #(.PORT_W(PORT_W)) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_lvl  (scl_lvl),
        .sda_lvl  (sda_lvl),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev),
        .addr_sel (addr_sel),
        .pin_sync (pin_sync),
        .sda_lo   (sda_pull_low),
        .addr_hit (addr_hit),
        .wr_stb   (wr_stb),
        .wr_grp   (wr_grp),
        .wr_data  (wr_data)
    );

    pexp_port #(.PORT_W(PORT_W)) u_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_raw  (pin_in),
        .scl_fall (scl_fall),
        .addr_hit (addr_hit),
        .wr_stb   (wr_stb),
        .wr_grp   (wr_grp),
        .wr_data  (wr_data),
        .pin_sync (pin_sync),
        .latch    (latch),
        .boost    (pin_boost),
        .irq_n    (irq_n)
    );

    assign pin_pull_low = ~latch;

endmodule

// File: tb/sim_pexp16_top.sv
// Directed bench: a bit-banged I2C controller drives scenarios, each task
// checks its own results.
module sim_pexp16_top;
    localparam int CLK_P = 10;
    localparam int Q     = 10;
    localparam logic [7:0] AW = 8'h4A;
    localparam logic [7:0] AR = 8'h4B;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic [15:0] ext = 16'hFFFF;
    logic [15:0] exp_lat = 16'hFFFF;
    logic        sda_pull_low, irq_n;
    logic [15:0] pin_pull_low, pin_boost, pin_in;
    wire         sda_bus = sda_m & ~sda_pull_low;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    assign pin_in = ext & ~pin_pull_low;

    always #(CLK_P/2) clk = ~clk;

    pexp16_top u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
        .sda_pull_low(sda_pull_low), .addr_sel(3'b101), .pin_in(pin_in),
        .pin_pull_low(pin_pull_low), .pin_boost(pin_boost), .irq_n(irq_n)
    );

    task automatic waitc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; waitc(Q);
        scl_m = 1'b1; waitc(Q);
        sda_m = 1'b0; waitc(Q);
        scl_m = 1'b0; waitc(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; waitc(Q);
        scl_m = 1'b1; waitc(Q);
        sda_m = 1'b1; waitc(2*Q);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b;    waitc(Q);
        scl_m = 1'b1; waitc(2*Q);
        scl_m = 1'b0; waitc(Q);
    endtask

    task automatic send_bits8(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic ack_high(output logic ack);
        sda_m = 1'b1; waitc(Q);
        scl_m = 1'b1; waitc(Q);
        ack = ~sda_bus;
        waitc(Q);
    endtask

    task automatic ack_low();
        scl_m = 1'b0; waitc(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        send_bits8(v);
        ack_high(ack);
        ack_low();
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] v);
        logic s0;
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; waitc(Q);
            scl_m = 1'b1; waitc(Q);
            s0 = sda_bus; v[i] = s0;
            waitc(Q - 1);
            chk("R7 sda stable while scl high", {15'd0, sda_bus}, {15'd0, s0});
            scl_m = 1'b0; waitc(Q + 1);
        end
        send_bit(~give_ack);
    endtask

    task automatic t_reset();
        chk("R1 pull_low", pin_pull_low, 16'h0000);
        chk("R1 boost", pin_boost, 16'h0000);
        chk("R1 irq_n", {15'd0, irq_n}, 16'd1);
        chk("R1 sda released", {15'd0, sda_pull_low}, 16'd0);
    endtask

    task automatic t_irq_read();
        logic a;
        logic [7:0] d;
        ext = 16'h3CA5; waitc(20);
        chk("R9 irq on change", {15'd0, irq_n}, 16'd0);
        bus_start();
        send_byte(AR, a);
        chk("R2 read address ack", {15'd0, a}, 16'd1);
        chk("R9 irq cleared by access", {15'd0, irq_n}, 16'd1);
        recv_byte(1'b1, d);
        chk("R6 read low group", {8'd0, d}, 16'h00A5);
        recv_byte(1'b0, d);
        chk("R6 read high group", {8'd0, d}, 16'h003C);
        bus_stop();
        chk("R6 nack released bus", {15'd0, sda_pull_low}, 16'd0);
        ext = 16'hFFFF; waitc(20);
    endtask

    task automatic t_addr_miss();
        logic a;
        bus_start();
        send_byte(8'h4E, a);
        chk("R2 foreign address no ack", {15'd0, a}, 16'd0);
        send_byte(8'h00, a);
        bus_stop();
        chk("R2 latch unchanged", pin_pull_low, ~exp_lat);
    endtask

    task automatic t_write_timing();
        logic a;
        bus_start();
        send_byte(AW, a);
        send_bits8(8'h5A);
        ack_high(a);
        chk("R4 ack given", {15'd0, a}, 16'd1);
        chk("R4 pins unchanged before ack end", pin_pull_low, ~exp_lat);
        ack_low();
        exp_lat[7:0] = 8'h5A;
        chk("R4 pins updated after ack", pin_pull_low, ~exp_lat);
        chk("R5 boost on written ones", pin_boost, 16'h005A);
        send_bit(1'b1);
        chk("R5 boost ends at next scl fall", pin_boost, 16'h0000);
        bus_stop();
        chk("R8 stop drops partial byte", pin_pull_low, ~exp_lat);
    endtask

    task automatic t_write_three();
        logic a;
        bus_start();
        send_byte(AW, a);
        send_byte(8'h12, a);
        send_byte(8'h34, a);
        chk("R5 boost high group", pin_boost, 16'h3400);
        send_byte(8'h56, a);
        bus_stop();
        exp_lat = 16'h3456;
        chk("R3 alternating groups", pin_pull_low, ~exp_lat);
    endtask

    task automatic t_rstart();
        logic a;
        bus_start();
        send_byte(AW, a);
        for (int i = 0; i < 4; i++) send_bit(1'b0);
        bus_start();
        send_byte(AW, a);
        send_byte(8'h0F, a);
        bus_stop();
        exp_lat[7:0] = 8'h0F;
        chk("R8 repeated start restarts at low group", pin_pull_low, ~exp_lat);
    endtask

    task automatic t_glitch();
        logic a;
        logic [7:0] v;
        v = 8'h96;
        bus_start();
        send_byte(AW, a);
        for (int i = 7; i >= 0; i--) begin
            sda_m = v[i]; waitc(Q);
            scl_m = 1'b1; waitc(Q);
            sda_m = ~v[i]; waitc(2);
            sda_m = v[i];  waitc(Q - 2);
            scl_m = 1'b0; waitc(3);
            scl_m = 1'b1; waitc(2);
            scl_m = 1'b0; waitc(Q - 5);
        end
        ack_high(a);
        ack_low();
        chk("R10 ack despite spikes", {15'd0, a}, 16'd1);
        send_byte(8'h69, a);
        bus_stop();
        exp_lat = 16'h6996;
        chk("R10 spikes ignored", pin_pull_low, ~exp_lat);
    endtask

    initial begin
        waitc(5);
        rst_n = 1'b1;
        waitc(5);
        t_reset();
        t_irq_read();
        t_addr_miss();
        t_write_timing();
        t_write_three();
        t_rstart();
        t_glitch();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule